// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Code Interface

This block is the digital front end of a four-channel, 12-bit converter with a parallel host port. The host picks a channel with a 2-bit address, drives a code on the write data bus and frames the access with an active-low chip select and a read/write select line. A write is committed into the addressed channel's staging register when chip select returns high. The code that feeds each converter sits in a second, output register per channel. That register changes only while a common load input is high. When load is high, all four output registers copy their staging registers on the same clock edge, so every channel updates together.

Stored staging codes can be read back through the same port. The result comes out on a registered read bus with an output-enable flag, which a pad ring turns into a three-state driver. A synchronous active-high reset puts every staging and output register to a preset code. A configuration pin picks that code: all zeros, or midscale.

Top module: `quad_dac_frontend`

## Requirements
- R1: On every clock edge with `rst` high, all staging and output registers take the preset code. The preset is 0x000 when `mid_sel` is 0 and 0x800 (only the top bit set) when `mid_sel` is 1.
- R2: A write commits on the first clock edge at which `cs_n` is sampled high after being sampled low. It commits only if `rd_wr` was 0 (write) on the last edge with `cs_n` low. The staging register at that edge's `addr` then takes that edge's `din`.
- R3: While `load` is low, a committed write leaves `dac_codes` unchanged.
- R4: On each clock edge with `load` high, every output register copies its channel's staging register. Channel n occupies bits [12n+11:12n] of `dac_codes`.
- R5: If `load` is high on the edge where a write commits, the written channel's output register takes the new code on that same edge.
- R6: If `cs_n` is 0 and `rd_wr` is 1 at a clock edge, then after that edge `bus_oe` is 1 and `bus_out` holds the staging code of `addr`. After any other edge, `bus_oe` is 0.
- R7: A read access changes no staging or output register.
- R8: Reset takes priority over a write commit and over `load` on the same edge.
- R9: A write changes only the addressed channel's staging register.
- R10: After `rst` falls, every register keeps the preset code until a write or a load changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the preset code |
| mid_sel | input | 1 | Preset select: 0 gives zero code, 1 gives midscale |
| cs_n | input | 1 | Active-low chip select; a rising edge commits a write |
| rd_wr | input | 1 | Access direction: 1 read, 0 write |
| addr | input | 2 | Channel select, 0 to 3 |
| din | input | 12 | Write data bus |
| load | input | 1 | Level-sensitive common load of all output registers |
| bus_out | output | 12 | Registered read data |
| bus_oe | output | 1 | Read bus drive enable |
| dac_codes | output | 48 | Four output register codes, channel 0 in the low bits |

## Verification
The assertions assume that `rst` is held for at least one edge before the run, so the chip-select history starts out idle. They also assume `mid_sel` is steady across the edge that follows a reset edge. The bench changes every input only at falling clock edges. It changes `mid_sel` only before it raises `rst`, and holds `rd_wr`, `addr` and `din` steady for the whole of each chip-select window. As a result, each committed write has a single, well-defined code and channel.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  typedef enum logic {
    ACC_WRITE = 1'b0,
    ACC_READ  = 1'b1
  } access_e;
endpackage

// File: rtl/dac_bus_capture.sv
module dac_bus_capture
  import quad_dac_pkg::*;
#(
  parameter int WIDTH  = 12,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WIDTH-1:0]  wr_data
);
  logic    cs_q;
  access_e acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b1;
      acc_q   <= ACC_READ;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      cs_q <= cs_n;
      if (!cs_n) begin
        acc_q   <= access_e'(rd_wr);
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end

  // commit on the chip-select rising edge of a write access
  assign wr_en = cs_n && !cs_q && (acc_q == ACC_WRITE);
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] preset,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             load,
  output logic [WIDTH-1:0] stage_code,
  output logic [WIDTH-1:0] dac_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_code <= preset;
      dac_code   <= preset;
    end else begin
      if (wr_en) stage_code <= wr_data;
      if (load)  dac_code   <= wr_en ? wr_data : stage_code;
    end
  end
endmodule

// File: rtl/dac_readback.sv
module dac_readback
  import quad_dac_pkg::*;
#(
  parameter int WIDTH  = 12,
  parameter int ADDR_W = 2,
  localparam int NCH   = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 rd_wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NCH*WIDTH-1:0] stage_flat,
  output logic [WIDTH-1:0]     bus_out,
  output logic                 bus_oe
);
  logic [WIDTH-1:0] sel_code;

  always_comb begin
    sel_code = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(i)) sel_code = stage_flat[i*WIDTH +: WIDTH];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
    end else begin
      bus_oe  <= !cs_n && (access_e'(rd_wr) == ACC_READ);
      bus_out <= sel_code;
    end
  end
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend #(
  parameter int WIDTH  = 12,
  parameter int ADDR_W = 2,
  localparam int NCH   = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mid_sel,
  input  logic                 cs_n,
  input  logic                 rd_wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WIDTH-1:0]     din,
  input  logic                 load,
  output logic [WIDTH-1:0]     bus_out,
  output logic                 bus_oe,
  output logic [NCH*WIDTH-1:0] dac_codes
);
  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0]     preset;
  logic                 wr_en;
  logic [ADDR_W-1:0]    wr_addr;
  logic [WIDTH-1:0]     wr_data;
  logic [NCH*WIDTH-1:0] stage_flat;

  assign preset = mid_sel ? MID_CODE : '0;

  dac_bus_capture #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr), .din(din),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dac_channel #(.WIDTH(WIDTH)) u_ch (
      .clk(clk), .rst(rst), .preset(preset),
      .wr_en(wr_en && (wr_addr == ADDR_W'(g))), .wr_data(wr_data), .load(load),
      .stage_code(stage_flat[g*WIDTH +: WIDTH]),
      .dac_code(dac_codes[g*WIDTH +: WIDTH])
    );
  end

  dac_readback #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rb (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
    .stage_flat(stage_flat), .bus_out(bus_out), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/quad_dac_frontend_chk.sv
module quad_dac_frontend_chk #(
  parameter int WIDTH  = 12,
  parameter int ADDR_W = 2,
  localparam int NCH   = 1 << ADDR_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mid_sel,
  input logic                 cs_n,
  input logic                 rd_wr,
  input logic                 load,
  input logic                 bus_oe,
  input logic [NCH*WIDTH-1:0] dac_codes
);
  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  AST_PRESET_AFTER_RESET: assert property (@(posedge clk)
    rst |=> dac_codes == {NCH{($past(mid_sel) ? MID_CODE : {WIDTH{1'b0}})}}); // R1

  AST_OUTPUTS_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dac_codes)); // R3

  AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && rd_wr) |=> bus_oe); // R6

  AST_OE_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !rd_wr) |=> !bus_oe); // R6
endmodule

bind quad_dac_frontend quad_dac_frontend_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mid_sel(mid_sel), .cs_n(cs_n), .rd_wr(rd_wr),
  .load(load), .bus_oe(bus_oe), .dac_codes(dac_codes)
);

// File: tb/quad_dac_frontend_test.sv
module quad_dac_frontend_test;
  localparam int W = 12;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst, mid_sel, cs_n, rd_wr, load;
  logic [1:0] addr;
  logic [W-1:0] din;
  logic [W-1:0] bus_out;
  logic bus_oe;
  logic [N*W-1:0] dac_codes;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] in_m [N];
  logic [W-1:0] dac_m [N];

  always #4 clk = ~clk;

  quad_dac_frontend uut (
    .clk(clk), .rst(rst), .mid_sel(mid_sel), .cs_n(cs_n), .rd_wr(rd_wr),
    .addr(addr), .din(din), .load(load), .bus_out(bus_out), .bus_oe(bus_oe),
    .dac_codes(dac_codes)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_dacs(string req);
    for (int i = 0; i < N; i++) chk(req, dac_codes[i*W +: W], dac_m[i]);
  endtask

  task automatic set_preset(logic m);
    for (int i = 0; i < N; i++) begin
      in_m[i]  = m ? 12'h800 : 12'h000;
      dac_m[i] = in_m[i];
    end
  endtask

  task automatic do_write(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); cs_n = 0; rd_wr = 0; addr = a; din = d;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
    in_m[a] = d;
  endtask

  task automatic do_read(string req, logic [1:0] a);
    @(negedge clk); cs_n = 0; rd_wr = 1; addr = a;
    @(negedge clk);
    chk(req, {11'b0, bus_oe}, 12'h001);
    chk(req, bus_out, in_m[a]);
    cs_n = 1; rd_wr = 0;
    @(negedge clk);
    chk(req, {11'b0, bus_oe}, 12'h000);
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
    for (int i = 0; i < N; i++) dac_m[i] = in_m[i];
  endtask

  task automatic t_reset(logic m);
    @(negedge clk); mid_sel = m; rst = 1;
    @(negedge clk);
    set_preset(m);
    check_dacs("R1");
    rst = 0;
    for (int i = 0; i < N; i++) do_read("R1", 2'(i));
  endtask

  task automatic t_write_no_load();
    do_write(2'd1, 12'hABC);
    check_dacs("R3");
    do_read("R2", 2'd1);
    do_read("R9", 2'd0);
    do_read("R9", 2'd2);
    do_read("R9", 2'd3);
    do_write(2'd3, 12'h123);
    check_dacs("R3");
    do_read("R2", 2'd3);
  endtask

  task automatic t_load();
    pulse_load();
    check_dacs("R4");
  endtask

  task automatic t_passthrough();
    do_write(2'd0, 12'h777);
    @(negedge clk); load = 1; cs_n = 0; rd_wr = 0; addr = 2'd2; din = 12'h5A5;
    @(negedge clk); cs_n = 1;
    @(negedge clk); load = 0;
    in_m[2] = 12'h5A5;
    for (int i = 0; i < N; i++) dac_m[i] = in_m[i];
    check_dacs("R5");
  endtask

  task automatic t_read_no_modify();
    do_read("R7", 2'd0);
    do_read("R7", 2'd2);
    check_dacs("R7");
    for (int i = 0; i < N; i++) do_read("R7", 2'(i));
  endtask

  task automatic t_reset_priority();
    @(negedge clk); mid_sel = 1; cs_n = 0; rd_wr = 0; addr = 2'd1; din = 12'h0F0;
    @(negedge clk); cs_n = 1; rst = 1; load = 1;
    @(negedge clk); rst = 0; load = 0;
    set_preset(1'b1);
    check_dacs("R8");
    do_read("R8", 2'd1);
  endtask

  task automatic t_hold();
    repeat (10) @(negedge clk);
    check_dacs("R10");
    do_read("R10", 2'd3);
    do_write(2'd3, 12'hFFF);
    check_dacs("R10");
    pulse_load();
    check_dacs("R10");
  endtask

  bit done = 0;

  initial begin
    rst = 1; mid_sel = 0; cs_n = 1; rd_wr = 0; load = 0; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    t_reset(1'b0);
    t_reset(1'b1);
    t_write_no_load();
    t_load();
    t_passthrough();
    t_read_no_modify();
    t_reset_priority();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule